// File: doc/BRIEF.md
# Correlator Acquisition Controller

This block runs a correlation measurement from start to finish and keeps the correlator's accumulators from overflowing during long runs. A four-state controller moves from idle to ready to running to finished. It is armed, then launched, and it ends either on a halt request or when a run-length timer expires. While it runs, the correlator chain accumulates. After each fixed dump period the controller pauses accumulation. It then steps a channel select across every accumulator, adds each value into a result RAM, and pulses a clear to the chain before accumulation resumes.

The result RAM is addressed by row and column, and channel `c` lives at row `c / COLS`, column `c % COLS`. When the run is finished the controller raises a done flag. A host-side reader can then stream the RAM through a simple registered read port, walking columns inside rows, until it acknowledges and the controller returns to idle. The dump period and run length are parameters, so a simulation can use short runs while silicon uses the real-time interval (2,000,000,000 cycles of a 100 MHz clock for a 20 s dump period).

Top module: `corr_acq_ctrl`

## Requirements
- R1: After reset the state is idle, and start, clear, stop and done are all low.
- R2: `arm_i` moves idle to ready, and `go_i` moves ready to running. `go_i` has no effect in idle.
- R3: In the ready state, clear is held high and start is low, so accumulators and counters begin from zero.
- R4: While running, start is high during accumulation and never for more than DUMP_PERIOD consecutive cycles. After DUMP_PERIOD accumulation cycles, start drops and the channel select walks 0 to NUM_CH-1, one step per cycle. Then clear is high for one cycle, and then start resumes.
- R5: The first dump of a run writes each channel's value into the RAM, replacing what is there. Later dumps in the same run add the value to the stored sum.
- R6: A halt request, or completion of RUN_LEN accumulation cycles, triggers a final dump. The dump is followed by the finished state, with the stop output high for exactly its first cycle and no clear pulse.
- R7: A halt arriving during a dump lets that dump complete and then ends the run without a clear.
- R8: In the finished state `done_o` is high and the state holds until `ack_i`, which returns it to idle.
- R9: `rd_data_o` presents, one cycle after the address, the RAM entry at row·COLS+col, which holds the sum for channel row·COLS+col.
- R10: `state_o` encodes idle=0, ready=1, running=2, finished=3, and only ever steps 0→1→2→3→0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm request (idle to ready) |
| go_i | input | 1 | Launch request (ready to running) |
| halt_i | input | 1 | Early end request |
| ack_i | input | 1 | Host acknowledge (finished to idle) |
| corr_start_o | output | 1 | Accumulation enable to the correlator chain |
| corr_stop_o | output | 1 | One-cycle end-of-run pulse to the chain |
| corr_clear_o | output | 1 | Accumulator clear to the chain |
| acc_sel_o | output | SEL_W | Channel select for the accumulator read |
| acc_val_i | input | ACC_W | Selected accumulator value |
| state_o | output | 2 | Controller state code |
| done_o | output | 1 | Results ready for streaming |
| rd_row_i | input | ROW_W | Result RAM row |
| rd_col_i | input | COL_W | Result RAM column |
| rd_data_o | output | RAM_W | Registered read data |

## Verification
Every cycle, the assertions check the following:
- the state order is legal;
- start and clear cannot be high together while running, and start never stays high longer than one dump period;
- the select steps by one through a dump;
- stop occurs only on entry to the finished state;
- the finished state holds until acknowledged.

Only the bench's scenarios can show the data side. These are that the first dump replaces stale sums while later dumps accumulate, that the timer and an early halt both end the run after a final dump, that a halt in mid-dump skips the clear, and that the row and column read returns the right channel's total.

// File: rtl/corr_acq_ctrl.sv
module corr_acq_ctrl #(
  parameter int unsigned ROWS        = 18,
  parameter int unsigned COLS        = 16,
  parameter int unsigned ACC_W       = 32,
  parameter int unsigned RAM_W       = 48,
  parameter int unsigned DUMP_PERIOD = 2000000000,
  parameter int unsigned RUN_LEN     = 32'd4000000000,
  localparam int unsigned NUM_CH     = ROWS * COLS,
  localparam int unsigned SEL_W      = $clog2(NUM_CH),
  localparam int unsigned ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned COL_W      = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             ack_i,
  output logic             corr_start_o,
  output logic             corr_stop_o,
  output logic             corr_clear_o,
  output logic [SEL_W-1:0] acc_sel_o,
  input  logic [ACC_W-1:0] acc_val_i,
  output logic [1:0]       state_o,
  output logic             done_o,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [RAM_W-1:0] rd_data_o
);

  localparam int unsigned PER_W = (DUMP_PERIOD > 1) ? $clog2(DUMP_PERIOD) : 1;
  localparam int unsigned RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  typedef enum logic [1:0] {S_IDLE, S_READY, S_RUN, S_DONE} state_t;
  typedef enum logic [1:0] {P_ACC, P_DUMP, P_CLR} phase_t;

  state_t           state;
  phase_t           phase;
  logic [PER_W-1:0] per_cnt;
  logic [RUN_W-1:0] run_cnt;
  logic [SEL_W-1:0] ch;
  logic             first, end_req, stop_q;
  logic [RAM_W-1:0] ram [NUM_CH];
  logic [SEL_W:0]   rd_addr;

  wire acc_now  = (state == S_RUN) && (phase == P_ACC);
  wire dump_now = (state == S_RUN) && (phase == P_DUMP);
  wire last_ch  = (ch == SEL_W'(NUM_CH - 1));
  wire run_hit  = (run_cnt == RUN_W'(RUN_LEN - 1));
  wire per_hit  = (per_cnt == PER_W'(DUMP_PERIOD - 1));

  assign corr_start_o = acc_now;
  assign corr_clear_o = (state == S_READY) || ((state == S_RUN) && (phase == P_CLR));
  assign corr_stop_o  = stop_q;
  assign acc_sel_o    = ch;
  assign state_o      = state;
  assign done_o       = (state == S_DONE);
  assign rd_addr      = (SEL_W+1)'(rd_row_i) * (SEL_W+1)'(COLS) + (SEL_W+1)'(rd_col_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= P_ACC;
      per_cnt <= '0;
      run_cnt <= '0;
      ch      <= '0;
      first   <= 1'b1;
      end_req <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      case (state)
        S_IDLE: if (arm_i) state <= S_READY;
        S_READY: begin
          first   <= 1'b1;
          end_req <= 1'b0;
          per_cnt <= '0;
          run_cnt <= '0;
          phase   <= P_ACC;
          if (go_i) state <= S_RUN;
        end
        S_RUN: begin
          case (phase)
            P_ACC: begin
              if (halt_i || end_req || run_hit) begin
                end_req <= 1'b1;
                phase   <= P_DUMP;
                ch      <= '0;
                per_cnt <= '0;
              end else begin
                run_cnt <= run_cnt + 1'b1;
                if (per_hit) begin
                  per_cnt <= '0;
                  phase   <= P_DUMP;
                  ch      <= '0;
                end else begin
                  per_cnt <= per_cnt + 1'b1;
                end
              end
            end
            P_DUMP: begin
              if (halt_i) end_req <= 1'b1;
              if (last_ch) begin
                first <= 1'b0;
                if (end_req || halt_i) begin
                  state  <= S_DONE;
                  stop_q <= 1'b1;
                  phase  <= P_ACC;
                end else begin
                  phase <= P_CLR;
                end
              end else begin
                ch <= ch + 1'b1;
              end
            end
            default: begin
              if (halt_i) end_req <= 1'b1;
              phase <= P_ACC;
            end
          endcase
        end
        default: if (ack_i) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (dump_now)
      ram[ch] <= first ? RAM_W'(acc_val_i) : ram[ch] + RAM_W'(acc_val_i);
    rd_data_o <= (rd_addr < (SEL_W+1)'(NUM_CH)) ? ram[rd_addr[SEL_W-1:0]] : '0;
  end

endmodule

// File: rtl/corr_acq_ctrl_chk.sv
module corr_acq_ctrl_chk #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned DUMP_PERIOD = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state_o,
  input logic             corr_start_o,
  input logic             corr_clear_o,
  input logic             corr_stop_o,
  input logic             ack_i,
  input logic [SEL_W-1:0] acc_sel_o
);

  logic [31:0] streak;
  wire dumping = (state_o == 2'd2) && !corr_start_o && !corr_clear_o;

  always_ff @(posedge clk) begin
    if (!rst_n) streak <= '0;
    else        streak <= corr_start_o ? streak + 1 : 32'd0;
  end

  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    corr_start_o |-> (state_o == 2'd2)); // R4
  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |-> (corr_clear_o && !corr_start_o)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    streak <= DUMP_PERIOD); // R4
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel_o < SEL_W'(NUM_CH)); // R4
  AST_DUMP_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (dumping && $past(dumping)) |-> (acc_sel_o == $past(acc_sel_o) + 1'b1)); // R4
  AST_STOP_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    corr_stop_o |-> (state_o == 2'd3 && $past(state_o) == 2'd2)); // R6
  AST_FINISH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !ack_i) |=> (state_o == 2'd3)); // R8
  AST_STATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o)) |-> (state_o == $past(state_o) + 2'd1)); // R10

endmodule

bind corr_acq_ctrl corr_acq_ctrl_chk #(
  .NUM_CH(NUM_CH), .SEL_W(SEL_W), .DUMP_PERIOD(DUMP_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .corr_start_o(corr_start_o),
  .corr_clear_o(corr_clear_o), .corr_stop_o(corr_stop_o), .ack_i(ack_i),
  .acc_sel_o(acc_sel_o)
);

// File: tb/test_corr_acq_ctrl.sv
`timescale 1ns/1ps
module test_corr_acq_ctrl;
  localparam int ROWS = 2, COLS = 3, NCH = 6, ACC_W = 16, RAM_W = 24;
  localparam int DP = 20, RL = 70;

  logic clk = 0, rst_n = 0;
  logic arm = 0, go = 0, halt = 0, ack = 0;
  logic start, stop, clear, done;
  logic [2:0] sel;
  logic [1:0] st;
  logic [0:0] row = 0;
  logic [1:0] col = 0;
  logic [RAM_W-1:0] rdata;
  logic [ACC_W-1:0] accv;
  int seed = 5;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  function automatic int accf(int c); return seed + c * 7; endfunction
  assign accv = ACC_W'(accf(int'(sel)));

  corr_acq_ctrl #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W), .RAM_W(RAM_W),
    .DUMP_PERIOD(DP), .RUN_LEN(RL)) i_corr_acq_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .go_i(go), .halt_i(halt), .ack_i(ack),
    .corr_start_o(start), .corr_stop_o(stop), .corr_clear_o(clear), .acc_sel_o(sel),
    .acc_val_i(accv), .state_o(st), .done_o(done), .rd_row_i(row), .rd_col_i(col),
    .rd_data_o(rdata));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int ms, mp, mper, mrun, mch, mfirst, mend, mstop;
  longint mram [NCH];
  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mp = 0; mper = 0; mrun = 0; mch = 0; mfirst = 1; mend = 0; mstop = 0;
    end else begin
      mstop = 0;
      case (ms)
        0: if (arm) ms = 1;
        1: begin mfirst = 1; mper = 0; mrun = 0; mend = 0; mp = 0; if (go) ms = 2; end
        2: if (mp == 0) begin
             if (halt || mend != 0 || mrun == RL - 1) begin mend = 1; mp = 1; mch = 0; mper = 0; end
             else begin
               mrun++;
               if (mper == DP - 1) begin mper = 0; mp = 1; mch = 0; end else mper++;
             end
           end else if (mp == 1) begin
             if (halt) mend = 1;
             mram[mch] = (mfirst != 0) ? longint'(accf(mch)) : mram[mch] + accf(mch);
             if (mch == NCH - 1) begin
               mfirst = 0;
               if (mend != 0) begin ms = 3; mstop = 1; mp = 0; end else mp = 2;
             end else mch++;
           end else begin
             if (halt) mend = 1;
             mp = 0;
           end
        default: if (ack) ms = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R10 state", st, ms);
    check("R4 start", start, (ms == 2 && mp == 0));
    check("R3 clear", clear, (ms == 1 || (ms == 2 && mp == 2)));
    check("R6 stop", stop, mstop);
    check("R8 done", done, (ms == 3));
    check("R4 sel", sel, mch);
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) tick();
  endtask

  task automatic read_all(string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        row = 1'(r); col = 2'(c);
        @(negedge clk);
        check(req, rdata, mram[r * COLS + c]);
        #1;
      end
  endtask

  task automatic launch();
    arm = 1; tick(); arm = 0;
    check("R3 ready clear", clear, 1);
    check("R3 ready start", start, 0);
    go = 1; tick(); go = 0;
  endtask

  int stops, clears;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state", st, 0);
    check("R1 start", start, 0);
    check("R1 clear", clear, 0);
    check("R1 stop", stop, 0);
    check("R1 done", done, 0);
    #1 rst_n = 1;
    tick();
    go = 1; tick(); go = 0; tick();
    check("R2 go ignored in idle", st, 0);

    // run 1: ends on timer, four dumps accumulate
    seed = 5;
    launch();
    check("R2 running", st, 2);
    stops = 0;
    for (int i = 0; i < 2000 && !done; i++) begin tick(); if (stop) stops++; end
    check("R6 timer end reached finish", st, 3);
    check("R6 single stop pulse", stops, 1);
    check("R5 four dumps summed ch0", mram[0], 4 * accf(0));
    read_all("R9 R5 readout run1");
    repeat (3) tick();
    check("R8 holds without ack", st, 3);
    ack = 1; tick(); ack = 0;
    check("R8 ack to idle", st, 0);

    // run 2: early halt, single dump must replace old sums
    seed = 11;
    launch();
    repeat (5) tick();
    halt = 1; tick(); halt = 0;
    clears = 0;
    for (int i = 0; i < 200 && !done; i++) begin tick(); if (clear) clears++; end
    check("R6 halt end no clear", clears, 0);
    check("R5 first dump replaces ch5", mram[5], accf(5));
    read_all("R9 R5 readout run2");
    ack = 1; tick(); ack = 0;

    // run 3: halt in the middle of a dump
    seed = 3;
    launch();
    for (int i = 0; i < 200 && !(st == 2 && !start && !clear && sel == 2); i++) tick();
    check("R7 reached mid dump", sel, 2);
    halt = 1; tick(); halt = 0;
    clears = 0;
    for (int i = 0; i < 200 && !done; i++) begin tick(); if (clear) clears++; end
    check("R7 finished after dump", st, 3);
    check("R7 no clear after halted dump", clears, 0);
    read_all("R9 R7 readout run3");
    ack = 1; tick(); ack = 0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule